// File: doc/BRIEF.md
# Driver Impedance Calibration Controller

This block tunes the output impedance of the data-pin drivers against an off-chip precision 240-ohm resistor. The tunable element is a bank of parallel pull-up legs. A 5-bit leg-enable code selects which legs are switched on, and the legs form a voltage divider with the external resistor. An analog comparator reports whether the divider node is still above the reference voltage. A calibration command, issued during initialization and again whenever voltage or temperature drift calls for it, starts the search.

The controller runs a successive-approximation search from the most significant code bit down. After each code change it waits a programmable settle interval of at least 16 clocks and then samples the comparator. A trial bit is kept while the divider is still above the reference. When all five bits are resolved, the result is written to the code shared by every data-pin driver. That write happens in a single cycle together with an update strobe, so no driver ever sees a half-updated code. The analog divider and the comparator are outside this block.

Top module: `zqcal_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o` and `update_o` are 0 and both `trial_code_o` and `final_code_o` are 5'b00000.
- R2: A `start_i` pulse seen while idle makes `busy_o` high and sets `trial_code_o` to 5'b10000 in the next cycle. The search runs from bit 4 down to bit 0.
- R3: At each sample the trial bit under test is kept if `cmp_above_i` is 1 and cleared if it is 0, and the next lower bit is then set to 1. With a comparator that is high exactly for codes up to some value T, the result is T, including T=0 and T=31.
- R4: The effective settle count is `settle_cycles_i` if that is at least 16, and 16 otherwise. It is captured when the start is accepted. After every code change the trial code holds for exactly that many cycles before the comparator is sampled.
- R5: `update_o` rises 5*S+1 clock edges after the edge that accepted the start, where S is the effective settle count.
- R6: `final_code_o` changes only in the cycle in which `update_o` is high. `update_o` is high for exactly one cycle per calibration.
- R7: `busy_o` stays high from the cycle after the start is accepted up to the cycle before `update_o` rises, and it is low in the cycle in which `update_o` is high.
- R8: A `start_i` pulse while `busy_o` is high is ignored. It does not change the latency, does not restart the search, and does not cause a second update afterwards.
- R9: `done_o` is 0 while a calibration is running. It becomes 1 together with `update_o` and stays 1 until the next accepted start. Repeated calibrations each publish their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Calibration command pulse |
| cmp_above_i | input | 1 | Comparator: divider node above reference |
| settle_cycles_i | input | 8 | Requested settle cycles per step (minimum 16 enforced) |
| trial_code_o | output | 5 | Leg-enable code currently under test |
| final_code_o | output | 5 | Calibrated code shared by all data-pin drivers |
| done_o | output | 1 | A calibration result has been published |
| update_o | output | 1 | One-cycle strobe marking a new final code |
| busy_o | output | 1 | Calibration sequence in progress |

## Verification
The hardest case to reach is a start command that lands in the middle of a running search. Such a command can only be seen as the absence of an effect: the search must neither restart nor run twice. The bench drives a start pulse partway through a run and then checks three things at the ports. The trial code at each settle boundary must follow the unrestarted schedule, the update must come at the original latency, and no second update may follow. A behavioural divider model in the bench switches the comparator at a chosen code, so the search can be steered to the extreme results 0 and 31 and to mid-range values.

// File: rtl/zqcal_pkg.sv
// Package: shared constants and types for the impedance calibration controller.
// Assumes: a 5-bit leg code and an 8-bit settle request field.
package zqcal_pkg;
    localparam int unsigned ZQ_CODE_W     = 5;
    localparam int unsigned ZQ_SETTLE_W   = 8;
    localparam int unsigned ZQ_MIN_SETTLE = 16;

    typedef enum logic {
        SAR_IDLE = 1'b0,
        SAR_RUN  = 1'b1
    } sar_state_e;
endpackage

// File: rtl/zqcal_settle_timer.sv
// Module: down-counter that times the comparator settle window.
// Assumes: load_i and run_i come from the search engine. expired_o is
// high while running with the count at zero.
module zqcal_settle_timer #(
    parameter int unsigned SETTLE_W = zqcal_pkg::ZQ_SETTLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                load_i,
    input  logic [SETTLE_W-1:0] load_val_i,
    output logic                expired_o
);
    logic [SETTLE_W-1:0] cnt_q;

    // Load the window on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The window is over once the count has reached zero.
    assign expired_o = run_i && (cnt_q == '0);

    AST_TIMER_STOPS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/zqcal_sar.sv
// Module: successive-approximation search over the leg code, MSB first.
// Assumes: the comparator is valid whenever the settle timer reports
// expiry. start_i is qualified by the caller so that it only arrives
// while the engine is idle.
module zqcal_sar #(
    parameter int unsigned CODE_W   = zqcal_pkg::ZQ_CODE_W,
    parameter int unsigned SETTLE_W = zqcal_pkg::ZQ_SETTLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cmp_above_i,
    input  logic                expired_i,
    input  logic [SETTLE_W-1:0] win_m1_i,
    output logic                run_o,
    output logic                load_o,
    output logic [SETTLE_W-1:0] load_val_o,
    output logic [CODE_W-1:0]   trial_o,
    output logic                result_vld_o
);
    import zqcal_pkg::*;

    localparam int unsigned IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

    sar_state_e          state_q;
    logic [IDX_W-1:0]    idx_q;
    logic [CODE_W-1:0]   trial_q;
    logic [CODE_W-1:0]   trial_nx;
    logic [SETTLE_W-1:0] win_q;
    logic                res_q;
    logic                sample;
    logic                last_bit;

    assign sample   = (state_q == SAR_RUN) && expired_i;
    assign last_bit = (idx_q == '0);

    // Next trial code: resolve the bit under test and arm the next lower one.
    always_comb begin
        trial_nx = trial_q;
        trial_nx[idx_q] = cmp_above_i;
        if (!last_bit) begin
            trial_nx[idx_q - 1'b1] = 1'b1;
        end
    end

    // Search state, bit pointer, trial code and captured settle window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SAR_IDLE;
            idx_q   <= '0;
            trial_q <= '0;
            win_q   <= '0;
            res_q   <= 1'b0;
        end else begin
            res_q <= 1'b0;
            if (state_q == SAR_IDLE) begin
                if (start_i) begin
                    state_q <= SAR_RUN;
                    idx_q   <= TOP_IDX;
                    trial_q <= {1'b1, {(CODE_W-1){1'b0}}};
                    win_q   <= win_m1_i;
                end
            end else if (sample) begin
                trial_q <= trial_nx;
                if (last_bit) begin
                    state_q <= SAR_IDLE;
                    res_q   <= 1'b1;
                end else begin
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end

    // Reload the timer on every code change that is followed by a sample.
    assign load_o       = ((state_q == SAR_IDLE) && start_i) || (sample && !last_bit);
    assign load_val_o   = (state_q == SAR_IDLE) ? win_m1_i : win_q;
    assign run_o        = (state_q == SAR_RUN);
    assign trial_o      = trial_q;
    assign result_vld_o = res_q;

    AST_CODE_HOLDS_WHILE_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SAR_RUN && !expired_i) |=> $stable(trial_q)); // R4
    AST_NO_RESTART_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SAR_RUN && !expired_i) |=> (state_q == SAR_RUN && $stable(idx_q))); // R8
endmodule

// File: rtl/zqcal_commit.sv
// Module: publishes the search result to the driver-wide code register.
// Assumes: result_vld_i is a one-cycle pulse with result_i valid in that
// cycle. The code and the strobe are updated by the same edge.
module zqcal_commit #(
    parameter int unsigned CODE_W = zqcal_pkg::ZQ_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_done_i,
    input  logic              result_vld_i,
    input  logic [CODE_W-1:0] result_i,
    output logic [CODE_W-1:0] final_o,
    output logic              update_o,
    output logic              done_o
);
    logic [CODE_W-1:0] final_q;
    logic              upd_q;
    logic              done_q;

    // Single-edge publish of code, strobe and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            final_q <= '0;
            upd_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            upd_q <= result_vld_i;
            if (result_vld_i) begin
                final_q <= result_i;
                done_q  <= 1'b1;
            end else if (clear_done_i) begin
                done_q <= 1'b0;
            end
        end
    end

    assign final_o  = final_q;
    assign update_o = upd_q;
    assign done_o   = done_q;

    AST_UPDATE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |=> !upd_q); // R6
    AST_FINAL_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !result_vld_i |=> $stable(final_q)); // R6
    AST_DONE_WITH_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |-> done_q); // R9
endmodule

// File: rtl/zqcal_ctrl.sv
// Module: top of the driver impedance calibration controller.
// Assumes: start_i is a command pulse and cmp_above_i reflects the divider
// for the current trial_code_o once the settle window has passed.
// Requests below the minimum settle count are raised to that minimum.
module zqcal_ctrl #(
    parameter int unsigned CODE_W     = zqcal_pkg::ZQ_CODE_W,
    parameter int unsigned SETTLE_W   = zqcal_pkg::ZQ_SETTLE_W,
    parameter int unsigned MIN_SETTLE = zqcal_pkg::ZQ_MIN_SETTLE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cmp_above_i,
    input  logic [SETTLE_W-1:0] settle_cycles_i,
    output logic [CODE_W-1:0]   trial_code_o,
    output logic [CODE_W-1:0]   final_code_o,
    output logic                done_o,
    output logic                update_o,
    output logic                busy_o
);
    localparam logic [SETTLE_W-1:0] MIN_M1 = SETTLE_W'(MIN_SETTLE - 1);

    logic                sar_run;
    logic                res_vld;
    logic                tmr_load;
    logic                tmr_exp;
    logic                start_ok;
    logic [SETTLE_W-1:0] win_m1;
    logic [SETTLE_W-1:0] tmr_val;

    // Clamp the requested window to the minimum, minus one for the counter.
    always_comb begin
        if (settle_cycles_i < SETTLE_W'(MIN_SETTLE)) begin
            win_m1 = MIN_M1;
        end else begin
            win_m1 = settle_cycles_i - 1'b1;
        end
    end

    assign busy_o   = sar_run || res_vld;
    assign start_ok = start_i && !busy_o;

    zqcal_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (sar_run),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    zqcal_sar #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_sar (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_ok),
        .cmp_above_i  (cmp_above_i),
        .expired_i    (tmr_exp),
        .win_m1_i     (win_m1),
        .run_o        (sar_run),
        .load_o       (tmr_load),
        .load_val_o   (tmr_val),
        .trial_o      (trial_code_o),
        .result_vld_o (res_vld)
    );

    zqcal_commit #(.CODE_W(CODE_W)) u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_done_i (start_ok),
        .result_vld_i (res_vld),
        .result_i     (trial_code_o),
        .final_o      (final_code_o),
        .update_o     (update_o),
        .done_o       (done_o)
    );

    AST_START_AT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (trial_code_o == {1'b1, {(CODE_W-1){1'b0}}})); // R2
    AST_NOT_BUSY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> !busy_o); // R7
    AST_DONE_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !update_o) |-> !done_o); // R9
endmodule

// File: tb/zqcal_ctrl_tb_top.sv
// Bench: directed scenarios against a behavioural divider/comparator model.
module zqcal_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] settle_cycles_i = 8'd0;
    logic [4:0] trial_code_o;
    logic [4:0] final_code_o;
    logic       done_o, update_o, busy_o;
    logic [4:0] tgt = 5'd0;
    logic       cmp_above_i;

    int n_tests = 0;
    int n_fail  = 0;

    // Divider model: node stays above reference while the code is at most the target.
    assign cmp_above_i = (trial_code_o <= tgt);

    always #2.5 clk = ~clk;

    zqcal_ctrl dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .cmp_above_i     (cmp_above_i),
        .settle_cycles_i (settle_cycles_i),
        .trial_code_o    (trial_code_o),
        .final_code_o    (final_code_o),
        .done_o          (done_o),
        .update_o        (update_o),
        .busy_o          (busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && update_o == 0, "R1 flags", {busy_o, done_o, update_o}, 0);
        chk(trial_code_o == 0, "R1 trial", trial_code_o, 0);
        chk(final_code_o == 0, "R1 final", final_code_o, 0);
    endtask

    // One calibration; optional extra start pulse mid-run (R8).
    task automatic t_cal(input int target, input int settle, input bit poke);
        int eff;
        int total;
        logic [4:0] old_final;
        bit busy_ok, upd_early, done_early;
        eff = (settle < 16) ? 16 : settle;
        total = 5 * eff + 2;
        tgt = 5'(target);
        settle_cycles_i = 8'(settle);
        old_final = final_code_o;
        busy_ok = 1; upd_early = 0; done_early = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);            // cycle 1
        start_i = 1'b0;
        settle_cycles_i = 8'd200;  // later change has no effect on this run (R4)
        chk(busy_o == 1, "R2 busy on start", busy_o, 1);
        chk(trial_code_o == 5'b10000, "R2 first trial", trial_code_o, 16);
        for (int c = 1; c < total; c++) begin
            if (c == eff) begin
                chk(trial_code_o == 5'b10000, "R4 code held through window", trial_code_o, 16);
            end
            if (c == eff + 1) begin
                chk(trial_code_o == {target[4], 4'b1000}, "R4 sample after window",
                    trial_code_o, {target[4], 4'b1000});
            end
            if (c == 2 * eff + 1) begin
                chk(trial_code_o == {target[4:3], 3'b100}, "R3 second step",
                    trial_code_o, {target[4:3], 3'b100});
            end
            if (poke && c == 10) start_i = 1'b1;
            if (poke && c == 11) start_i = 1'b0;
            if (!busy_o) busy_ok = 0;
            if (update_o) upd_early = 1;
            if (done_o) done_early = 0 == 1 ? 1 : 1;
            if (final_code_o != old_final) upd_early = 1;
            @(negedge clk);
        end
        chk(busy_ok, "R7 busy held during run", busy_ok, 1);
        chk(!upd_early, "R6 no early update or final change", upd_early, 0);
        chk(!done_early, "R9 done low while running", done_early, 0);
        chk(update_o == 1, "R5 update at 5*S+1 edges", update_o, 1);
        chk(busy_o == 0, "R7 busy low with update", busy_o, 0);
        chk(final_code_o == 5'(target), "R3 final code", final_code_o, target);
        chk(done_o == 1, "R9 done with update", done_o, 1);
        @(negedge clk);
        chk(update_o == 0, "R6 update one cycle", update_o, 1'b0);
        if (poke) begin
            bit extra;
            extra = 0;
            for (int c = 0; c < 100; c++) begin
                if (busy_o || update_o) extra = 1;
                @(negedge clk);
            end
            chk(!extra, "R8 ignored start caused no second run", extra, 0);
            chk(final_code_o == 5'(target) && done_o, "R8 result kept", final_code_o, target);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cal(21, 0, 0);   // R3 R4 R5 minimum window
        t_cal(31, 40, 0);  // R3 upper extreme, longer window
        t_cal(0, 16, 1);   // R3 lower extreme with mid-run start (R8)
        t_cal(10, 5, 0);   // R9 recalibration after drift, clamp to 16
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule